// File: doc/BRIEF.md
# Product-Term Steering Logic Block

This block is the combinational core of one generic logic block in a programmable logic fabric. Forty-four routed input signals feed an AND plane of eighty-two product terms. Each term may take any input as a true literal, as a complement literal, or not at all. Eighty of the terms are general purpose. They are split into twenty groups of four, and group k holds terms 4k to 4k+3. A steering stage hands these groups to twenty function outputs, and each output ORs the terms of the groups it owns.

Each output has one 8-bit steering field. The field lets the output widen its sum of products over neighbouring groups, up to seven groups (28 terms). It can instead take its own home group directly through a bypass, which suits functions of four terms or fewer. The last two terms are never summed. Term 80 is brought out as a shared product-term clock, and term 81 is brought out as an I/O control signal. Local feedback (up to 20 of the inputs) is wired outside this block onto the ordinary routed inputs. The configuration is a static bit vector that is held while the block is in use.

Top module: `pts_array`

## Requirements
- R1: Term t ANDs every input i whose true-select bit `and_true_cfg[t*44+i]` is 1.
- R2: Term t ANDs the complement of every input i whose complement-select bit `and_comp_cfg[t*44+i]` is 1.
- R3: A term with no select bit set evaluates to 1. A term that selects both the true and the complement form of one input evaluates to 0.
- R4: Group k is made of terms 4k..4k+3. When output o has its share-enable bit (`steer_cfg[o*8+6]`) set and both span counts are zero, it gives the OR of group o.
- R5: With share enabled, output o claims groups o-lo to o+hi. Here lo is `steer_cfg[o*8+2:o*8]` and hi is `steer_cfg[o*8+5:o*8+3]`, and groups outside 0..19 are dropped. A claim with lo+hi greater than 6 claims nothing, so the largest sum is 7 groups (28 terms).
- R6: Each group has at most one owner. An output in bypass always owns its home group. Any other group claimed by several outputs goes to the lowest-index claimant.
- R7: When the bypass bit `steer_cfg[o*8+7]` is set, output o is the OR of group o alone, whatever its span and share-enable bits hold.
- R8: An output with neither share enable nor bypass set, or one that owns no group, drives 0.
- R9: `shared_clk_pt` is term 80 and `io_ctl_pt` is term 81. Neither term reaches any function output.
- R10: Every output is a combinational function of the current inputs and configuration. No clock edge is needed for a change to appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_sig | input | 44 | Routed input signals |
| and_true_cfg | input | 3608 | True-literal selects, 44 bits per term, term 0 lowest |
| and_comp_cfg | input | 3608 | Complement-literal selects, same layout |
| steer_cfg | input | 160 | Per-output steering field, 8 bits each, output 0 lowest |
| fn_out | output | 20 | Sum-of-products function outputs |
| shared_clk_pt | output | 1 | Term 80, shared clock candidate |
| io_ctl_pt | output | 1 | Term 81, I/O control signal |

## Verification
The checks are immediate assertions evaluated whenever the combinational logic changes. They take for granted that the configuration vectors are static while outputs are read, and that the inputs hold known 0/1 values. The bench therefore changes the configuration and the inputs only between samples, and it waits a short delay after each change before it reads an output. It also sets every unused general term to a deliberate contradiction so that it reads 0. That keeps the "empty term is 1" rule from lighting up outputs that a test does not target.

// File: rtl/pts_pkg.sv
// Package: default geometry of the product-term steering block.
// Assumes: one steering field per output, laid out as lo span, hi span,
// share enable, bypass (lowest bit first).
package pts_pkg;
    localparam int PTS_N_IN    = 44;
    localparam int PTS_N_OUT   = 20;
    localparam int PTS_GRP_W   = 4;
    localparam int PTS_MAX_GRP = 7;

    // Width of one span count field.
    function automatic int span_bits(input int max_grp);
        return (max_grp <= 2) ? 1 : $clog2(max_grp);
    endfunction
endpackage

// File: rtl/pts_and_plane.sv
// Module: pts_and_plane
// Forms every product term from the routed inputs. Each term has one
// true-select and one complement-select mask. Assumes masks are static.
module pts_and_plane #(
    parameter int N_IN   = pts_pkg::PTS_N_IN,
    parameter int N_TERM = 82
) (
    input  logic [N_IN-1:0]        in_sig,
    input  logic [N_TERM*N_IN-1:0] sel_true,
    input  logic [N_TERM*N_IN-1:0] sel_comp,
    output logic [N_TERM-1:0]      term
);
    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        logic [N_IN-1:0] lit_ok;
        // Purpose: a literal passes when unselected or when its form is satisfied.
        assign lit_ok  = (~sel_true[t*N_IN +: N_IN] | in_sig)
                       & (~sel_comp[t*N_IN +: N_IN] | ~in_sig);
        assign term[t] = &lit_ok;
    end
endmodule

// File: rtl/pts_owner.sv
// Module: pts_owner
// Decodes per-output steering fields into a group ownership matrix
// own[g][o]. A bypass output holds its home group. Other groups go to the
// lowest-index claimant. Assumes steering fields are static.
module pts_owner #(
    parameter int N_OUT   = pts_pkg::PTS_N_OUT,
    parameter int MAX_GRP = pts_pkg::PTS_MAX_GRP,
    localparam int SPAN_W = pts_pkg::span_bits(MAX_GRP),
    localparam int CFG_W  = 2*SPAN_W + 2
) (
    input  logic [N_OUT*CFG_W-1:0]        steer_cfg,
    output logic [N_OUT-1:0][N_OUT-1:0]   own
);
    logic [N_OUT-1:0][N_OUT-1:0] claim;   // [o][g]
    logic [N_OUT-1:0]            byp;

    // Purpose: turn each output's span fields into a claim on a window of groups.
    always_comb begin
        for (int o = 0; o < N_OUT; o++) begin
            int  lo_v;
            int  hi_v;
            logic en_v;
            lo_v   = int'(steer_cfg[o*CFG_W +: SPAN_W]);
            hi_v   = int'(steer_cfg[o*CFG_W + SPAN_W +: SPAN_W]);
            en_v   = steer_cfg[o*CFG_W + 2*SPAN_W];
            byp[o] = steer_cfg[o*CFG_W + 2*SPAN_W + 1];
            for (int g = 0; g < N_OUT; g++) begin
                claim[o][g] = en_v && !byp[o] && (lo_v + hi_v <= MAX_GRP - 1)
                              && (g >= o - lo_v) && (g <= o + hi_v);
            end
        end
    end

    // Purpose: resolve claims so that every group has at most one owner.
    always_comb begin
        for (int g = 0; g < N_OUT; g++) begin
            logic taken;
            own[g]    = '0;
            own[g][g] = byp[g];
            taken     = byp[g];
            for (int o = 0; o < N_OUT; o++) begin
                if (claim[o][g] && !taken) begin
                    own[g][o] = 1'b1;
                    taken     = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pts_sum.sv
// Module: pts_sum
// ORs each group's four terms, then ORs the groups owned by each output.
// Assumes the ownership matrix holds at most one owner per group.
module pts_sum #(
    parameter int N_OUT = pts_pkg::PTS_N_OUT,
    parameter int GRP_W = pts_pkg::PTS_GRP_W
) (
    input  logic [N_OUT*GRP_W-1:0]      gen_term,
    input  logic [N_OUT-1:0][N_OUT-1:0] own,
    output logic [N_OUT-1:0]            fn_out
);
    logic [N_OUT-1:0] grp_or;

    for (genvar g = 0; g < N_OUT; g++) begin : g_grp
        assign grp_or[g] = |gen_term[g*GRP_W +: GRP_W];
    end

    // Purpose: each output sums the groups it owns.
    always_comb begin
        for (int o = 0; o < N_OUT; o++) begin
            logic acc;
            acc = 1'b0;
            for (int g = 0; g < N_OUT; g++) begin
                acc = acc | (own[g][o] & grp_or[g]);
            end
            fn_out[o] = acc;
        end
    end
endmodule

// File: rtl/pts_array.sv
// Module: pts_array (top)
// One logic block: AND plane, group steering and output sums, plus the
// two extra terms brought out. Purely combinational; assumes static config.
module pts_array #(
    parameter int N_IN    = pts_pkg::PTS_N_IN,
    parameter int N_OUT   = pts_pkg::PTS_N_OUT,
    parameter int GRP_W   = pts_pkg::PTS_GRP_W,
    parameter int MAX_GRP = pts_pkg::PTS_MAX_GRP,
    localparam int N_GEN  = N_OUT * GRP_W,
    localparam int N_TERM = N_GEN + 2,
    localparam int CFG_W  = 2*pts_pkg::span_bits(MAX_GRP) + 2
) (
    input  logic [N_IN-1:0]        in_sig,
    input  logic [N_TERM*N_IN-1:0] and_true_cfg,
    input  logic [N_TERM*N_IN-1:0] and_comp_cfg,
    input  logic [N_OUT*CFG_W-1:0] steer_cfg,
    output logic [N_OUT-1:0]       fn_out,
    output logic                   shared_clk_pt,
    output logic                   io_ctl_pt
);
    logic [N_TERM-1:0]           term;
    logic [N_OUT-1:0][N_OUT-1:0] own;

    pts_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_plane (
        .in_sig   (in_sig),
        .sel_true (and_true_cfg),
        .sel_comp (and_comp_cfg),
        .term     (term)
    );

    pts_owner #(.N_OUT(N_OUT), .MAX_GRP(MAX_GRP)) u_owner (
        .steer_cfg (steer_cfg),
        .own       (own)
    );

    pts_sum #(.N_OUT(N_OUT), .GRP_W(GRP_W)) u_sum (
        .gen_term (term[N_GEN-1:0]),
        .own      (own),
        .fn_out   (fn_out)
    );

    // Purpose: the two extra terms leave the block unsummed.
    assign shared_clk_pt = term[N_GEN];
    assign io_ctl_pt     = term[N_GEN+1];
endmodule

// File: rtl/pts_chk.sv
// Module: pts_chk
// Immediate assertions on the steering block, attached by bind.
// Assumes configuration and inputs are settled, known values.
module pts_chk #(
    parameter int N_IN    = pts_pkg::PTS_N_IN,
    parameter int N_OUT   = pts_pkg::PTS_N_OUT,
    parameter int GRP_W   = pts_pkg::PTS_GRP_W,
    parameter int MAX_GRP = pts_pkg::PTS_MAX_GRP,
    localparam int N_GEN  = N_OUT * GRP_W,
    localparam int N_TERM = N_GEN + 2,
    localparam int SPAN_W = pts_pkg::span_bits(MAX_GRP),
    localparam int CFG_W  = 2*SPAN_W + 2
) (
    input logic [N_TERM*N_IN-1:0]   and_true_cfg,
    input logic [N_TERM*N_IN-1:0]   and_comp_cfg,
    input logic [N_OUT*CFG_W-1:0]   steer_cfg,
    input logic [N_TERM-1:0]        term,
    input logic [N_OUT-1:0][N_OUT-1:0] own,
    input logic [N_OUT-1:0]         fn_out,
    input logic                     shared_clk_pt,
    input logic                     io_ctl_pt
);
    // Purpose: term-level literal rules.
    always_comb begin
        for (int t = 0; t < N_TERM; t++) begin
            if (|(and_true_cfg[t*N_IN +: N_IN] & and_comp_cfg[t*N_IN +: N_IN]))
                a_r3_conflict_zero: assert (!term[t]);
            if (and_true_cfg[t*N_IN +: N_IN] == '0 && and_comp_cfg[t*N_IN +: N_IN] == '0)
                a_r3_empty_one: assert (term[t]);
        end
    end

    // Purpose: the extra terms reach their own outputs (R9).
    always_comb begin
        if (and_true_cfg[N_GEN*N_IN +: N_IN] == '0 && and_comp_cfg[N_GEN*N_IN +: N_IN] == '0)
            a_r9_clk_term: assert (shared_clk_pt);
        if (and_true_cfg[(N_GEN+1)*N_IN +: N_IN] == '0 && and_comp_cfg[(N_GEN+1)*N_IN +: N_IN] == '0)
            a_r9_ioctl_term: assert (io_ctl_pt);
    end

    // Purpose: ownership and per-output steering rules.
    always_comb begin
        for (int g = 0; g < N_OUT; g++) begin
            a_r6_single_owner: assert ($onehot0(own[g]));
        end
        for (int o = 0; o < N_OUT; o++) begin
            int   lo_v;
            int   hi_v;
            logic en_v;
            logic by_v;
            lo_v = int'(steer_cfg[o*CFG_W +: SPAN_W]);
            hi_v = int'(steer_cfg[o*CFG_W + SPAN_W +: SPAN_W]);
            en_v = steer_cfg[o*CFG_W + 2*SPAN_W];
            by_v = steer_cfg[o*CFG_W + 2*SPAN_W + 1];
            if (!en_v && !by_v)
                a_r8_idle_zero: assert (!fn_out[o]);
            if (by_v)
                a_r7_bypass_home: assert (fn_out[o] == |term[o*GRP_W +: GRP_W]);
            if (!by_v && (lo_v + hi_v > MAX_GRP - 1))
                a_r5_span_limit: assert (!fn_out[o]);
        end
    end
endmodule

bind pts_array pts_chk #(
    .N_IN(N_IN), .N_OUT(N_OUT), .GRP_W(GRP_W), .MAX_GRP(MAX_GRP)
) u_chk (
    .and_true_cfg  (and_true_cfg),
    .and_comp_cfg  (and_comp_cfg),
    .steer_cfg     (steer_cfg),
    .term          (term),
    .own           (own),
    .fn_out        (fn_out),
    .shared_clk_pt (shared_clk_pt),
    .io_ctl_pt     (io_ctl_pt)
);

// File: tb/sim_pts_array.sv
// Directed bench for pts_array: one task per scenario, each checking itself.
module sim_pts_array;
    localparam int NI = 44;
    localparam int NO = 20;
    localparam int NT = 82;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic [NI-1:0]    in_sig;
    logic [NT*NI-1:0] at_cfg;
    logic [NT*NI-1:0] ac_cfg;
    logic [NO*CW-1:0] st_cfg;
    logic [NO-1:0]    fn_out;
    logic             clk_pt;
    logic             ioc_pt;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #5 clk = ~clk;

    pts_array u0 (
        .in_sig        (in_sig),
        .and_true_cfg  (at_cfg),
        .and_comp_cfg  (ac_cfg),
        .steer_cfg     (st_cfg),
        .fn_out        (fn_out),
        .shared_clk_pt (clk_pt),
        .io_ctl_pt     (ioc_pt)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_term(input int t, input logic [NI-1:0] tm, input logic [NI-1:0] cm);
        at_cfg[t*NI +: NI] = tm;
        ac_cfg[t*NI +: NI] = cm;
    endtask

    // Every term forced to 0 (true and complement of input 0), steering idle.
    task automatic clear_all();
        for (int t = 0; t < NT; t++) set_term(t, 44'd1, 44'd1);
        st_cfg = '0;
        in_sig = '0;
    endtask

    // Field: [2:0] lo, [5:3] hi, [6] share enable, [7] bypass.
    task automatic set_out(input int o, input int lo, input int hi, input bit en, input bit byp);
        st_cfg[o*CW +: CW] = {byp, en, hi[2:0], lo[2:0]};
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic t_initial();
        at_cfg = '0; ac_cfg = '0; st_cfg = '0; in_sig = '0;
        settle();
        check("R8 idle outputs", 32'(fn_out), 32'h0);
        check("R3 empty extra terms", {30'd0, clk_pt, ioc_pt}, 32'h3);
    endtask

    task automatic t_literals();
        clear_all();
        set_term(0, (44'd1 << 3) | (44'd1 << 5), '0);
        set_out(0, 0, 0, 1'b1, 1'b0);
        in_sig = (44'd1 << 3) | (44'd1 << 5);
        settle();
        check("R1 true literals met", 32'(fn_out[0]), 32'd1);
        in_sig = 44'd1 << 3;
        settle();
        check("R1 one literal missing", 32'(fn_out[0]), 32'd0);
    endtask

    task automatic t_complement();
        clear_all();
        set_term(5, 44'd1 << 2, 44'd1 << 7);
        set_out(1, 0, 0, 1'b1, 1'b0);
        in_sig = 44'd1 << 2;
        settle();
        check("R2 complement satisfied", 32'(fn_out[1]), 32'd1);
        in_sig = (44'd1 << 2) | (44'd1 << 7);
        settle();
        check("R2 complement violated", 32'(fn_out[1]), 32'd0);
        check("R4 group 1 only on out1", 32'(fn_out), 32'h0);
    endtask

    task automatic t_conflict();
        clear_all();
        set_term(8, 44'd1 << 10, 44'd1 << 10);
        set_out(2, 0, 0, 1'b1, 1'b0);
        in_sig = '1;
        settle();
        check("R3 conflicting term", 32'(fn_out[2]), 32'd0);
        set_term(9, '0, '0);
        settle();
        check("R3 empty term in group 2", 32'(fn_out[2]), 32'd1);
    endtask

    task automatic t_span();
        clear_all();
        set_out(10, 3, 3, 1'b1, 1'b0);
        set_term(28, '0, '0);
        settle();
        check("R5 low edge group 7", 32'(fn_out), 32'h400);
        set_term(28, 44'd1, 44'd1);
        set_term(55, '0, '0);
        settle();
        check("R5 high edge group 13 term 55", 32'(fn_out), 32'h400);
        set_term(55, 44'd1, 44'd1);
        set_term(56, '0, '0);
        settle();
        check("R5 group 14 outside span", 32'(fn_out), 32'h0);
        clear_all();
        set_out(0, 0, 6, 1'b1, 1'b0);
        set_term(27, '0, '0);
        settle();
        check("R5 seven groups from out0", 32'(fn_out), 32'h1);
    endtask

    task automatic t_limit();
        clear_all();
        set_out(10, 4, 3, 1'b1, 1'b0);
        set_term(40, '0, '0);
        settle();
        check("R5 span over seven groups", 32'(fn_out), 32'h0);
    endtask

    task automatic t_overlap();
        clear_all();
        set_out(3, 0, 2, 1'b1, 1'b0);
        set_out(5, 1, 0, 1'b1, 1'b0);
        set_term(17, '0, '0);
        settle();
        check("R6 group 4 to lower claimant", 32'(fn_out), 32'h8);
        set_term(17, 44'd1, 44'd1);
        set_term(21, '0, '0);
        settle();
        check("R6 group 5 to lower claimant", 32'(fn_out), 32'h8);
        set_term(21, 44'd1, 44'd1);
        set_term(18, '0, '0);
        set_out(4, 0, 0, 1'b0, 1'b1);
        settle();
        check("R6 bypass keeps home group", 32'(fn_out), 32'h10);
    endtask

    task automatic t_bypass();
        clear_all();
        set_out(7, 2, 1, 1'b1, 1'b1);
        set_term(24, '0, '0);
        settle();
        check("R7 bypass ignores span", 32'(fn_out), 32'h0);
        set_term(31, '0, '0);
        settle();
        check("R7 bypass home group", 32'(fn_out), 32'h80);
    endtask

    task automatic t_extra();
        clear_all();
        for (int o = 0; o < NO; o++) set_out(o, 0, 6, 1'b1, 1'b0);
        set_term(80, '0, '0);
        set_term(81, '0, 44'd1 << 9);
        in_sig = '0;
        settle();
        check("R9 extra terms out", {30'd0, clk_pt, ioc_pt}, 32'h3);
        check("R9 extra terms not summed", 32'(fn_out), 32'h0);
        in_sig = 44'd1 << 9;
        settle();
        check("R9 io control term follows input", 32'(ioc_pt), 32'd0);
    endtask

    task automatic t_comb();
        clear_all();
        set_term(76, 44'd1 << 43, '0);
        set_out(19, 0, 0, 1'b1, 1'b0);
        @(posedge clk);
        #2;
        in_sig = 44'd1 << 43;
        #1;
        check("R10 rise between edges", 32'(fn_out[19]), 32'd1);
        in_sig = '0;
        #1;
        check("R10 fall between edges", 32'(fn_out[19]), 32'd0);
    endtask

    initial begin
        t_initial();
        t_literals();
        t_complement();
        t_conflict();
        t_span();
        t_limit();
        t_overlap();
        t_bypass();
        t_extra();
        t_comb();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule